// File: doc/BRIEF.md
# Self-Clearing Soft Reset Controller

This block owns one configuration register of a peripheral subsystem and turns a software write into an ordered reset of that subsystem and its two child controllers. When software sets bit 0 of the register, the block raises a reset pulse of fixed length to the subsystem and both children. It then waits in a settle phase until every child reports ready, and only then lets bit 0 read back as 0. Software therefore starts a reset by read-modify-write and polls the same bit for completion.

The register port uses a valid/ready request and a registered response one cycle later. The port never stalls. While the reset pulse is being driven, no register state can be touched: every access, read or write, completes with an error response instead of hanging. Once the pulse has ended, bit 0 can be polled normally while the children finish coming up.

The register also holds one active-low access-enable bit per child. These bits are brought out as active-high enables for the children's register paths. All other bits are plain storage that survives a soft reset request.

Top module: `soft_reset_ctrl`

## Requirements
- R1: After hardware reset the register reads 0x0028 (bit 0 reads 0), `subsys_rst` is low, every `child_rst_n` is high and every `child_acc_en` is high.
- R2: A write to the register address (0x10) with bit 0 set, accepted while no reset is running, asserts `subsys_rst` and drives every `child_rst_n` low from the next cycle, for exactly ceil(PULSE_NS / clock period) cycles (20 cycles at 100 MHz and 200 ns).
- R3: A write with bit 0 clear starts no reset. It stores bits 15..1 as written.
- R4: While the pulse is driven, every accepted access gets `rsp_err`=1 with `rsp_rdata`=0, and it changes no register bit.
- R5: Bit 0 reads 1 from the start of a reset until the pulse has ended and all `child_ready` inputs have been sampled high at a clock edge after the pulse. It reads 0 from the next access on.
- R6: Bits 15..1 keep their value across a soft reset request; a read during or after the settle phase returns them unchanged.
- R7: A write with bit 0 set while a reset is already running (settle phase) does not start a new pulse and does not lengthen the sequence.
- R8: `child_acc_en[i]` is the inverse of register bit 8+i (bit value 0 enables access to child i).
- R9: An access to any address other than 0x10 gets `rsp_err`=1 and `rsp_rdata`=0, and it changes nothing.
- R10: `bus_ready` is always high, and each accepted access produces exactly one `rsp_valid` pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_err | output | 1 | Error response (pulse window or unmapped address) |
| rsp_rdata | output | 16 | Read data; 0 on writes and errors |
| child_ready | input | 2 | Ready indication from each child controller |
| subsys_rst | output | 1 | Active-high subsystem reset pulse |
| child_rst_n | output | 2 | Active-low reset to each child controller |
| child_acc_en | output | 2 | Register access enable to each child |

## Verification
The bench builds the block with its defaults: a 10,000 ps clock period and a 200 ns window, which gives a 20-cycle pulse. With that length, the pulse can be counted edge by edge and the bench can still place accesses deep inside the window. The children's ready lines are driven from the bench. This lets the settle phase be held open as long as needed, so bit 0 can be polled, a second start can be attempted mid-sequence, and completion can be observed on the exact cycle after the children come up. The 16-bit data width with enable bits at 8 and 9 lets the table walk cover storage bits, enable bits and the reset value in separate rows.

// File: rtl/srst_pkg.sv
package srst_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_PULSE  = 2'd1,
    SQ_SETTLE = 2'd2
  } seq_state_e;

  // Smallest whole number of clock cycles covering the no-access window.
  function automatic int unsigned pulse_cycles(input int unsigned period_ps,
                                               input int unsigned win_ns);
    int unsigned c;
    c = (win_ns * 1000 + period_ps - 1) / period_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/srst_seq.sv
module srst_seq
  import srst_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 20,
  parameter int unsigned N_CHILD   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [N_CHILD-1:0] child_ready_i,
  output logic               pulse_o,
  output logic               busy_o,
  output logic               settle_done_o
);

  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             start_ok, pulse_end, all_ready;

  assign start_ok      = start_i && (state_q == SQ_IDLE);
  assign pulse_end     = (state_q == SQ_PULSE) && (cnt_q == LAST);
  assign all_ready     = &child_ready_i;
  assign settle_done_o = (state_q == SQ_SETTLE) && all_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:   if (start_ok)      state_d = SQ_PULSE;
      SQ_PULSE:  if (pulse_end)     state_d = SQ_SETTLE;
      SQ_SETTLE: if (settle_done_o) state_d = SQ_IDLE;
      default:                      state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SQ_PULSE) cnt_q <= cnt_q + 1'b1;
      else                     cnt_q <= '0;
    end
  end

  assign pulse_o = (state_q == SQ_PULSE);
  assign busy_o  = (state_q != SQ_IDLE);

  // R2
  pulse_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(start_i));

  // R2
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (cnt_q < CNT_W'(PULSE_CYC)));

  // R5
  done_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(all_ready) && !$past(pulse_o));

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> !$past(busy_o));

endmodule

// File: rtl/srst_regfile.sv
module srst_regfile #(
  parameter int unsigned      ADDR_W   = 8,
  parameter int unsigned      DATA_W   = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h10,
  parameter logic [DATA_W-1:0] RST_VAL  = 16'h0028,
  parameter int unsigned      EN_LSB   = 8,
  parameter int unsigned      N_CHILD  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               busy_i,
  input  logic               pulse_i,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               start_o,
  output logic [N_CHILD-1:0] acc_en_o
);

  localparam logic [DATA_W-1:0] KEEP_MASK = ~DATA_W'(1);

  logic [DATA_W-1:0] cfg_q;
  logic              hit, acc_ok, wr_ok, rd_ok, bad_acc;
  logic [DATA_W-1:0] rd_view;

  assign hit     = (bus_addr == CFG_ADDR);
  assign acc_ok  = bus_valid && hit && !pulse_i;
  assign wr_ok   = acc_ok && bus_write;
  assign rd_ok   = acc_ok && !bus_write;
  assign bad_acc = bus_valid && !acc_ok;
  assign start_o = wr_ok && bus_wdata[0];
  assign rd_view = (cfg_q & KEEP_MASK) | DATA_W'(busy_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= RST_VAL & KEEP_MASK;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (wr_ok) cfg_q <= bus_wdata & KEEP_MASK;
      rsp_valid <= bus_valid;
      rsp_err   <= bad_acc;
      rsp_rdata <= rd_ok ? rd_view : '0;
    end
  end

  for (genvar i = 0; i < N_CHILD; i++) begin : g_acc
    assign acc_en_o[i] = ~cfg_q[EN_LSB + i];
  end

  // R4
  pulse_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |=> $stable(cfg_q));

  // R4
  pulse_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && pulse_i) |=> (rsp_valid && rsp_err));

  // R10
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> rsp_valid);

  // R9
  unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !hit) |=> (rsp_err && rsp_rdata == '0));

endmodule

// File: rtl/soft_reset_ctrl.sv
module soft_reset_ctrl
  import srst_pkg::*;
#(
  parameter int unsigned       CLK_PERIOD_PS = 10000,
  parameter int unsigned       PULSE_NS      = 200,
  parameter int unsigned       ADDR_W        = 8,
  parameter int unsigned       DATA_W        = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR      = 8'h10,
  parameter logic [DATA_W-1:0] RST_VAL       = 16'h0028,
  parameter int unsigned       EN_LSB        = 8,
  parameter int unsigned       N_CHILD       = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  output logic               bus_ready,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic [N_CHILD-1:0] child_ready,
  output logic               subsys_rst,
  output logic [N_CHILD-1:0] child_rst_n,
  output logic [N_CHILD-1:0] child_acc_en
);

  localparam int unsigned PULSE_CYC = pulse_cycles(CLK_PERIOD_PS, PULSE_NS);

  logic start_req, pulse, busy, settle_done;

  srst_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR),
    .RST_VAL(RST_VAL), .EN_LSB(EN_LSB), .N_CHILD(N_CHILD)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy_i(busy), .pulse_i(pulse),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .start_o(start_req), .acc_en_o(child_acc_en)
  );

  srst_seq #(.PULSE_CYC(PULSE_CYC), .N_CHILD(N_CHILD)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_req), .child_ready_i(child_ready),
    .pulse_o(pulse), .busy_o(busy), .settle_done_o(settle_done)
  );

  assign bus_ready  = 1'b1;
  assign subsys_rst = pulse;

  for (genvar i = 0; i < N_CHILD; i++) begin : g_crst
    assign child_rst_n[i] = ~pulse;
  end

  // R5
  settle_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done |-> busy && !subsys_rst);

endmodule

// File: tb/test_soft_reset_ctrl.sv
`timescale 1ns/1ps
module test_soft_reset_ctrl;

  localparam int CLK_NS    = 10;
  localparam int EXP_PULSE = (200 + CLK_NS - 1) / CLK_NS;
  localparam logic [7:0] CFG = 8'h10;
  localparam int NV = 11;
  // {wr, addr[8], wdata[16], exp_err, exp_rdata[16], exp_acc[2]}
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, CFG,   16'h0000, 1'b0, 16'h0028, 2'b11},
    {1'b1, CFG,   16'h0028, 1'b0, 16'h0000, 2'b11},
    {1'b1, CFG,   16'h0128, 1'b0, 16'h0000, 2'b10},
    {1'b0, CFG,   16'h0000, 1'b0, 16'h0128, 2'b10},
    {1'b0, 8'h04, 16'h0000, 1'b1, 16'h0000, 2'b10},
    {1'b1, 8'h14, 16'hFFFF, 1'b1, 16'h0000, 2'b10},
    {1'b0, CFG,   16'h0000, 1'b0, 16'h0128, 2'b10},
    {1'b1, CFG,   16'hAA56, 1'b0, 16'h0000, 2'b01},
    {1'b0, CFG,   16'h0000, 1'b0, 16'hAA56, 2'b01},
    {1'b1, CFG,   16'h0028, 1'b0, 16'h0000, 2'b11},
    {1'b0, CFG,   16'h0000, 1'b0, 16'h0028, 2'b11}
  };

  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [7:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [1:0]  child_ready = 0;
  logic        bus_ready, rsp_valid, rsp_err, subsys_rst;
  logic [15:0] rsp_rdata;
  logic [1:0]  child_rst_n, child_acc_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  soft_reset_ctrl i_soft_reset_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .child_ready(child_ready), .subsys_rst(subsys_rst),
    .child_rst_n(child_rst_n), .child_acc_en(child_acc_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xact(input logic wr, input logic [7:0] a, input logic [15:0] d,
                      output logic err, output logic [15:0] rd);
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = d;
    chk("R10 ready", {31'd0, bus_ready}, 1);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    chk("R10 rsp_valid", {31'd0, rsp_valid}, 1);
    err = rsp_err; rd = rsp_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * CLK_NS);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic e; logic [15:0] r; int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 subsys_rst", {31'd0, subsys_rst}, 0);
    chk("R1 child_rst_n", {30'd0, child_rst_n}, 2'b11);
    chk("R1 child_acc_en", {30'd0, child_acc_en}, 2'b11);
    chk("R10 idle rsp_valid", {31'd0, rsp_valid}, 0);

    // Table walk: R1, R3, R8, R9 in idle
    for (int i = 0; i < NV; i++) begin
      xact(VEC[i][43], VEC[i][42:35], VEC[i][34:19], e, r);
      chk($sformatf("R9/R3 err row %0d", i), {31'd0, e}, VEC[i][18]);
      chk($sformatf("R1/R3 rdata row %0d", i), {16'd0, r}, VEC[i][17:2]);
      chk($sformatf("R8 acc row %0d", i), {30'd0, child_acc_en}, VEC[i][1:0]);
      chk($sformatf("R3 no pulse row %0d", i), {31'd0, subsys_rst}, 0);
    end

    // Run 1: pulse length, polling, no restart (R2, R5, R6, R7)
    child_ready = 2'b00;
    xact(1, CFG, 16'h0029, e, r);
    chk("R2 start err", {31'd0, e}, 0);
    chk("R2 child_rst_n low", {30'd0, child_rst_n}, 2'b00);
    cnt = 0;
    while (subsys_rst && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    chk("R2 pulse length", cnt, EXP_PULSE);
    chk("R2 child_rst_n released", {30'd0, child_rst_n}, 2'b11);
    xact(0, CFG, 0, e, r);
    chk("R5 busy while not ready", {16'd0, r}, 16'h0029);
    chk("R5 settle read err", {31'd0, e}, 0);
    repeat (5) @(negedge clk);
    xact(1, CFG, 16'h0029, e, r);
    chk("R7 settle write err", {31'd0, e}, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 no restart", {31'd0, subsys_rst}, 0);
    end
    xact(0, CFG, 0, e, r);
    chk("R6 bits kept, R5 still busy", {16'd0, r}, 16'h0029);
    @(negedge clk);
    child_ready = 2'b11;
    xact(0, CFG, 0, e, r);
    chk("R5 bit0 clears after ready", {16'd0, r}, 16'h0028);
    chk("R7 no pulse after done", {31'd0, subsys_rst}, 0);

    // Run 2: accesses inside the pulse window (R4)
    xact(1, CFG, 16'h0029, e, r);
    chk("R2 second start", {31'd0, subsys_rst}, 1);
    xact(0, CFG, 0, e, r);
    chk("R4 read err in pulse", {31'd0, e}, 1);
    chk("R4 read data in pulse", {16'd0, r}, 0);
    xact(1, CFG, 16'h0300, e, r);
    chk("R4 write err in pulse", {31'd0, e}, 1);
    chk("R4 acc_en unchanged", {30'd0, child_acc_en}, 2'b11);
    while (subsys_rst) @(negedge clk);
    @(negedge clk);
    xact(0, CFG, 0, e, r);
    chk("R4 register unchanged after pulse", {16'd0, r}, 16'h0028);
    chk("R4 err cleared", {31'd0, e}, 0);

    // Hardware reset mid-sequence returns to R1 state
    xact(1, CFG, 16'h0129, e, r);
    rst_n = 0;
    @(negedge clk);
    chk("R1 async reset clears pulse", {31'd0, subsys_rst}, 0);
    rst_n = 1;
    xact(0, CFG, 0, e, r);
    chk("R1 value after hw reset", {16'd0, r}, 16'h0028);
    chk("R1 acc_en after hw reset", {30'd0, child_acc_en}, 2'b11);

    finish_run();
  end

endmodule